// File: doc/BRIEF.md
# Even/Odd Pixel Black-Level Balancer

This block follows a 10-bit converter whose samples come alternately from two ping-pong sampling channels. The two channels settle at slightly different black levels, and that mismatch shows up as a fixed pattern between neighbouring pixels. While the optical-black clamp window is open, the block keeps a separate low-pass black-level estimate for each channel. On every sample it then shifts even and odd samples towards each other by half the estimated mismatch, so both channels report the same black level.

A three-state window machine follows the clamp input. The states are `ST_WAIT` (no window seen since reset), `ST_CLAMP` (window open) and `ST_LIVE` (window closed after at least one window). `ST_WAIT` and `ST_LIVE` move to `ST_CLAMP` when the window opens. `ST_CLAMP` moves to `ST_LIVE` when the window closes. A state that sees no such event keeps its value. Entering `ST_CLAMP` restarts the channel parity at even, so each line maps its pixels to the channels in the same way. The correction path holds two more register stages than the bypass path. The blanking input forces the output to zero for any sample taken while it is low.

Top module: `eo_offset_corrector`

## Requirements
- R1: During reset `dout` is 0 and both estimates are cleared. Until a clamp window has been seen, corrected output equals the input sample.
- R2: With `corr_bypass`=1, `dout` holds the sample taken at the previous clock edge, unchanged.
- R3: With `corr_bypass`=0, a sample reaches `dout` three edges after it is taken. That is exactly two edges more than in bypass.
- R4: Sample parity (0 = even, 1 = odd) toggles on every clock. The first sample after reset is even, and the first sample of every clamp window is even, whatever the parity before it.
- R5: While the window is active, the estimate E of the sample's channel (DW+FRAC bits, FRAC fractional bits) becomes E + floor((sample·2^FRAC − E) / 2^LEAK_SHIFT).
- R6: Let h = floor((E_even − E_odd) / 2^(FRAC+1)). Even samples output sample − h and odd samples output sample + h, using the estimates after the sample's own update.
- R7: The corrected result saturates to the range 0 to 2^DW−1.
- R8: `clamp_pol`=0 makes `clamp_in` low mean window active. `clamp_pol`=1 makes high mean active.
- R9: A sample taken while `blank_n`=0 appears as 0 at `dout`, in both bypass and corrected modes.
- R10: Samples taken outside the window leave both estimates unchanged, so later corrections are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_data | input | DW | Converter sample, channels interleaved |
| clamp_in | input | 1 | Optical-black clamp window, polarity set by `clamp_pol` |
| blank_n | input | 1 | Pixel blanking, active low, zeroes the output |
| corr_bypass | input | 1 | 1 = correction bypassed, 0 = correction applied |
| clamp_pol | input | 1 | 0 = window active low, 1 = window active high |
| dout | output | DW | Corrected or passed-through sample |

## Verification
The bench builds the block with DW=10, FRAC=4 and LEAK_SHIFT=2. With that leak the estimates come close to the black levels within a dozen clamp samples, so short windows produce half-differences of tens of codes. Those sizes are enough to drive the output into both saturation rails and to show a parity slip as a clearly wrong value. An odd number of samples between two windows puts the parity restart within reach, and a window of equal levels under the high-active polarity tests the polarity select.

// File: rtl/eo_corr_pkg.sv
package eo_corr_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_CLAMP = 2'd1,
        ST_LIVE  = 2'd2
    } win_state_t;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } parity_t;

endpackage

// File: rtl/eo_window_fsm.sv
module eo_window_fsm
    import eo_corr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clamp_in,
    input  logic    clamp_pol,
    output logic    track_en,
    output logic    win_start,
    output parity_t sample_par
);
    win_state_t state_q, state_n;
    parity_t    par_q;
    logic       win_act;

    assign win_act = clamp_pol ? clamp_in : ~clamp_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            par_q   <= PAR_ODD;
        end else begin
            state_q <= state_n;
            par_q   <= sample_par;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state_q;
        win_start = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                win_start = win_act;
                if (win_act) state_n = ST_CLAMP;
            end
            ST_CLAMP: begin
                if (!win_act) state_n = ST_LIVE;
            end
            ST_LIVE: begin
                win_start = win_act;
                if (win_act) state_n = ST_CLAMP;
            end
            default: state_n = ST_WAIT;
        endcase
        track_en   = win_act;
        sample_par = win_start ? PAR_EVEN : parity_t'(~par_q);
    end

endmodule

// File: rtl/eo_black_tracker.sv
module eo_black_tracker #(
    parameter int DW         = 10,
    parameter int FRAC       = 4,
    parameter int LEAK_SHIFT = 3,
    localparam int EW        = DW + FRAC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [DW-1:0] din,
    output logic [EW-1:0] est
);
    logic signed [EW:0] err, step;
    logic [EW-1:0]      est_q;

    assign err  = $signed({1'b0, din, {FRAC{1'b0}}}) - $signed({1'b0, est_q});
    assign step = err >>> LEAK_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   est_q <= '0;
        else if (upd) est_q <= est_q + step[EW-1:0];
    end

    assign est = est_q;
endmodule

// File: rtl/eo_correct_pipe.sv
module eo_correct_pipe
    import eo_corr_pkg::*;
#(
    parameter int DW   = 10,
    parameter int FRAC = 4,
    localparam int EW  = DW + FRAC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  parity_t       par_in,
    input  logic          blank_n,
    input  logic          bypass,
    input  logic [EW-1:0] est_even,
    input  logic [EW-1:0] est_odd,
    output logic [DW-1:0] dout
);
    localparam logic signed [DW+1:0] MAXV = $signed({2'b00, {DW{1'b1}}});

    logic [DW-1:0]        s1_data, s2_data, sat;
    parity_t              s1_par;
    logic                 s1_keep;
    logic signed [EW:0]   diff, half;
    logic signed [DW+1:0] halfw, adj;

    always_comb begin
        diff  = $signed({1'b0, est_even}) - $signed({1'b0, est_odd});
        half  = diff >>> (FRAC + 1);
        halfw = $signed(half[DW+1:0]);
        if (s1_par == PAR_ODD) adj = $signed({2'b00, s1_data}) + halfw;
        else                   adj = $signed({2'b00, s1_data}) - halfw;
        if (adj < 0)          sat = '0;
        else if (adj > MAXV)  sat = {DW{1'b1}};
        else                  sat = adj[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_data <= '0;
            s1_par  <= PAR_EVEN;
            s1_keep <= 1'b0;
            s2_data <= '0;
            dout    <= '0;
        end else begin
            s1_data <= din;
            s1_par  <= par_in;
            s1_keep <= blank_n;
            s2_data <= s1_keep ? sat : '0;
            if (bypass) dout <= blank_n ? din : '0;
            else        dout <= s2_data;
        end
    end
endmodule

// File: rtl/eo_offset_corrector.sv
module eo_offset_corrector
    import eo_corr_pkg::*;
#(
    parameter int DW         = 10,
    parameter int FRAC       = 4,
    parameter int LEAK_SHIFT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] adc_data,
    input  logic          clamp_in,
    input  logic          blank_n,
    input  logic          corr_bypass,
    input  logic          clamp_pol,
    output logic [DW-1:0] dout
);
    localparam int EW = DW + FRAC;

    logic          track_en, win_start;
    parity_t       sample_par;
    logic [EW-1:0] est [2];
    logic [EW-1:0] est_even, est_odd;

    eo_window_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clamp_in   (clamp_in),
        .clamp_pol  (clamp_pol),
        .track_en   (track_en),
        .win_start  (win_start),
        .sample_par (sample_par)
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        localparam parity_t CH = (c == 0) ? PAR_EVEN : PAR_ODD;
        eo_black_tracker #(.DW(DW), .FRAC(FRAC), .LEAK_SHIFT(LEAK_SHIFT)) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (track_en && (sample_par == CH)),
            .din   (adc_data),
            .est   (est[c])
        );
    end

    assign est_even = est[0];
    assign est_odd  = est[1];

    eo_correct_pipe #(.DW(DW), .FRAC(FRAC)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (adc_data),
        .par_in   (sample_par),
        .blank_n  (blank_n),
        .bypass   (corr_bypass),
        .est_even (est_even),
        .est_odd  (est_odd),
        .dout     (dout)
    );
endmodule

// File: rtl/eo_offset_corrector_chk.sv
module eo_offset_corrector_chk #(
    parameter int DW = 10,
    parameter int EW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] adc_data,
    input logic          blank_n,
    input logic          corr_bypass,
    input logic          track_en,
    input logic          win_start,
    input logic          sample_par,
    input logic [EW-1:0] est_even,
    input logic [EW-1:0] est_odd,
    input logic [DW-1:0] dout
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r2_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_bypass && blank_n) |=> (dout == $past(adc_data)));

    a_r9_blank_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_bypass && !blank_n) |=> (dout == '0));

    a_r9_blank_corr: assert property (@(posedge clk) disable iff (!rst_n)
        (!corr_bypass && !blank_n) ##2 !corr_bypass |=> (dout == '0));

    a_r4_even_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |-> (sample_par == 1'b0));

    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !win_start) |-> (sample_par != $past(sample_par)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !track_en |=> ($stable(est_even) && $stable(est_odd)));
endmodule

bind eo_offset_corrector eo_offset_corrector_chk #(.DW(DW), .EW(DW + FRAC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_data    (adc_data),
    .blank_n     (blank_n),
    .corr_bypass (corr_bypass),
    .track_en    (track_en),
    .win_start   (win_start),
    .sample_par  (sample_par),
    .est_even    (est_even),
    .est_odd     (est_odd),
    .dout        (dout)
);

// File: tb/tb_eo_offset_corrector.sv
module tb_eo_offset_corrector;
    localparam int DW = 10, FRAC = 4, LEAK_SHIFT = 2;
    localparam int MAXV = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic clamp_in = 1'b1, blank_n = 1'b1, corr_bypass = 1'b1, clamp_pol = 1'b0;
    logic [DW-1:0] dout;

    eo_offset_corrector #(.DW(DW), .FRAC(FRAC), .LEAK_SHIFT(LEAK_SHIFT)) dut (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .clamp_in(clamp_in),
        .blank_n(blank_n), .corr_bypass(corr_bypass), .clamp_pol(clamp_pol), .dout(dout)
    );

    always #10 clk = ~clk;

    typedef struct { int due; int val; string req; } exp_t;
    exp_t q[$];
    int cyc = 0, n_chk = 0, n_err = 0;
    int m_est[2] = '{0, 0};
    bit m_pprev = 1'b1, m_actprev = 1'b0, m_byp = 1'b1, m_pol = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input int got, input int exp, input string req);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic bit idle_raw();
        return m_pol ? 1'b0 : 1'b1;
    endfunction

    task automatic drive(input int d, input bit raw, input bit bn, input bit chk, input string req);
        bit act, par;
        int half, v;
        exp_t it;
        @(negedge clk);
        adc_data = d[DW-1:0]; clamp_in = raw; blank_n = bn;
        corr_bypass = m_byp; clamp_pol = m_pol;
        act = m_pol ? raw : !raw;
        par = (act && !m_actprev) ? 1'b0 : !m_pprev;
        if (act) m_est[par] = m_est[par] + (((d <<< FRAC) - m_est[par]) >>> LEAK_SHIFT);
        m_pprev = par; m_actprev = act;
        half = (m_est[0] - m_est[1]) >>> (FRAC + 1);
        if (m_byp) begin
            it.val = bn ? d : 0;
            it.due = cyc + 1;
        end else begin
            v = par ? d + half : d - half;
            if (v < 0) v = 0;
            if (v > MAXV) v = MAXV;
            it.val = bn ? v : 0;
            it.due = cyc + 3;
        end
        it.req = req;
        if (chk) q.push_back(it);
    endtask

    task automatic set_mode(input bit byp);
        while (q.size() > 0) drive(0, idle_raw(), 1'b1, 1'b0, "");
        m_byp = byp;
    endtask

    // monitor: compare outputs as they become due
    always @(posedge clk) begin : mon
        exp_t it;
        #5;
        while (q.size() > 0 && q[0].due <= cyc) begin
            it = q.pop_front();
            if (it.due < cyc) check(-1, it.val, it.req);
            else              check(int'(dout), it.val, it.req);
        end
    end

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(int'(dout), 0, "R1");              // R1 reset value
        rst_n = 1'b1;

        // bypass mode
        drive(5, 1, 1, 1, "R2");
        drive(1000, 1, 1, 1, "R2");
        drive(333, 1, 1, 1, "R2");
        drive(777, 1, 0, 1, "R9");
        drive(12, 1, 1, 1, "R2");

        set_mode(1'b0);
        drive(100, 1, 1, 1, "R1");               // estimates still zero
        drive(200, 1, 1, 1, "R3");
        drive(300, 1, 1, 1, "R3");

        // first window: even 40, odd 60 (active low)
        for (int i = 0; i < 16; i++) drive((i % 2) ? 60 : 40, 0, 1, 1, "R5");
        for (int i = 0; i < 8; i++)  drive(500, 1, 1, 1, "R6");
        for (int i = 0; i < 6; i++)  drive(1000 - 7 * i, 1, 1, 1, "R10");
        for (int i = 0; i < 3; i++)  drive(450, 1, 1, 1, "R10");
        // window restart after odd sample count: parity must restart even
        for (int i = 0; i < 8; i++)  drive((i % 2) ? 60 : 40, 0, 1, 1, "R4");
        for (int i = 0; i < 4; i++)  drive(500, 1, 1, 1, "R4");

        // saturation: even black far above odd black
        for (int i = 0; i < 20; i++) drive((i % 2) ? 20 : 100, 0, 1, 1, "R5");
        for (int i = 0; i < 3; i++) begin
            drive(10, 1, 1, 1, "R7");
            drive(1010, 1, 1, 1, "R7");
        end

        // high-active window polarity
        m_pol = 1'b1;
        for (int i = 0; i < 12; i++) drive(300, 1, 1, 1, "R8");
        for (int i = 0; i < 6; i++)  drive(500 + i, 0, 1, 1, "R8");

        // blanking in corrected mode
        drive(900, 0, 0, 1, "R9");
        drive(901, 0, 1, 1, "R9");
        drive(902, 0, 0, 1, "R9");

        while (q.size() > 0) drive(0, idle_raw(), 1'b1, 1'b0, "");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule